// File: doc/BRIEF.md
# Bridge Excitation and Demodulation Phase Generator

This block runs on the oscillator clock and derives every timing signal for a phase-domain delta-sigma readout of an RC bridge from one free-running phase counter of 2^CNT_W states (32 by default). The counter produces a square-wave bridge excitation at the oscillator frequency divided by 32. For a 16 MHz oscillator this is 500 kHz. The counter also produces one sample strobe per excitation period for the modulator.

Two reference square waves share the same counter. Each reference has 50% duty and a rising edge at a programmable count offset. The modulator's one-bit decision picks which of the two references goes to the chopper demodulator. Over many periods the bitstream average then settles where the selected reference sits in quadrature with the bridge phase shift. The decision is latched once per period and held. The reference path therefore changes source only at a period boundary, never part way through a period.

Top module: `bridge_phase_gen`

## Requirements
- R1: While rst_ni is low, the block holds phase count 0. In this state drive_o=1, strobe_o=1 and bit_o=0. After release, the first clock edge moves the block to count 1.
- R2: drive_o is high for counts 0..15 and low for counts 16..31, so one excitation period is 32 clocks.
- R3: strobe_o is high for exactly one clock in every 32, at count 0. drive_o rises only in a cycle where strobe_o is high.
- R4: Reference k (k = 0 for phase_off0_i, k = 1 for phase_off1_i) is high when (count − offset_k) mod 32 is below 16. Its rising edge is at count offset_k.
- R5: bit_o takes the value of mod_bit_i at the clock edge that ends a strobe cycle. At every other edge bit_o is unchanged, so changes of mod_bit_i outside the strobe cycle are ignored.
- R6: ref_o equals reference 1 when bit_o=1 and reference 0 when bit_o=0.
- R7: With an offset of 0, the reference equals drive_o. With an offset of 16, the reference is the inverse of drive_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_off0_i | input | CNT_W | Rising-edge count of reference 0 |
| phase_off1_i | input | CNT_W | Rising-edge count of reference 1 |
| mod_bit_i | input | 1 | Modulator decision bit |
| drive_o | output | 1 | Bridge excitation square wave |
| ref_o | output | 1 | Selected demodulation reference |
| strobe_o | output | 1 | Modulator sample strobe, one per period |
| bit_o | output | 1 | Latched decision bit that controls ref_o |

## Verification
Several offset pairs are applied: a quarter-period pair (8, 24), the degenerate pair (0, 16) and the wrap-adjacent pair (31, 1). Together they separate a correct modular subtraction from an off-by-one or a missing wrap. The decision bit is driven in two ways. In one, it alternates once per period, which shows the selection actually switching. In the other, it toggles on every clock, which exposes any capture outside the strobe cycle. A reset asserted mid-period confirms that every output realigns to count 0.

// File: rtl/bridge_phase_pkg.sv
package bridge_phase_pkg;
  parameter int unsigned DEF_CNT_W = 5;

  typedef enum logic {
    SEL_REF0 = 1'b0,
    SEL_REF1 = 1'b1
  } ref_sel_e;
endpackage

// File: rtl/bridge_phase_cnt.sv
module bridge_phase_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             drive_o,
  output logic             strobe_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o    = cnt_q;
  assign drive_o  = ~cnt_q[CNT_W-1];
  assign strobe_o = (cnt_q == '0);

  a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  a_r3_drive_rise_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> strobe_o);
  a_r2_drive_fall_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_o) |-> $past(drive_o) && !strobe_o);
endmodule

// File: rtl/bridge_ref_wave.sv
module bridge_ref_wave #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             wave_o
);
  logic [CNT_W-1:0] rel;

  // position within the shifted period; wraps modulo 2^CNT_W
  assign rel    = cnt_i - off_i;
  assign wave_o = ~rel[CNT_W-1];

  a_r4_ref_rise_at_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wave_o) && $stable(off_i) && $stable(cnt_i) == 1'b0) |-> (cnt_i == off_i));
endmodule

// File: rtl/bridge_sel_latch.sv
module bridge_sel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic bit_i,
  output logic bit_o
);
  import bridge_phase_pkg::*;

  ref_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SEL_REF0;
    else if (strobe_i) sel_q <= ref_sel_e'(bit_i);
  end

  assign bit_o = sel_q;

  a_r5_hold_off_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i) |-> $stable(bit_o));
  a_r5_capture_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strobe_i) |-> (bit_o == $past(bit_i)));
endmodule

// File: rtl/bridge_phase_gen.sv
module bridge_phase_gen #(
  parameter int unsigned CNT_W = bridge_phase_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] phase_off0_i,
  input  logic [CNT_W-1:0] phase_off1_i,
  input  logic             mod_bit_i,
  output logic             drive_o,
  output logic             ref_o,
  output logic             strobe_o,
  output logic             bit_o
);
  localparam int unsigned N_REF = 2;

  logic [CNT_W-1:0]            cnt;
  logic [N_REF-1:0][CNT_W-1:0] offs;
  logic [N_REF-1:0]            waves;
  logic                        drive, strobe, sel;

  assign offs[0] = phase_off0_i;
  assign offs[1] = phase_off1_i;

  bridge_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_o    (cnt),
    .drive_o  (drive),
    .strobe_o (strobe)
  );

  for (genvar k = 0; k < N_REF; k++) begin : g_ref
    bridge_ref_wave #(.CNT_W(CNT_W)) u_wave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .off_i  (offs[k]),
      .wave_o (waves[k])
    );
  end

  bridge_sel_latch u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .bit_i    (mod_bit_i),
    .bit_o    (sel)
  );

  assign drive_o  = drive;
  assign strobe_o = strobe;
  assign bit_o    = sel;
  assign ref_o    = waves[sel];

  // R6: source changes only at a period boundary
  a_r6_ref_src_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe) |-> $stable(sel));
  a_r1_strobe_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> drive);
endmodule

// File: tb/bridge_phase_gen_test.sv
module bridge_phase_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 5;
  localparam int N   = 32;
  localparam int HLF = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] off0 = '0, off1 = '0;
  logic         mbit = 1'b0;
  logic         drive, refw, strobe, bitq;

  int n_chk = 0, n_bad = 0;
  int cnt_m = 0;
  int bit_m = 0;
  bit done = 1'b0;

  bridge_phase_gen #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_off0_i(off0), .phase_off1_i(off1),
    .mod_bit_i(mbit), .drive_o(drive), .ref_o(refw), .strobe_o(strobe), .bit_o(bitq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: count and latched bit
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_m <= 0;
      bit_m <= 0;
    end else begin
      if (cnt_m == 0) bit_m <= int'(mbit);
      cnt_m <= (cnt_m + 1) % N;
    end
  end

  function automatic bit ref_lvl(int c, int off);
    return ((c - off + N) % N) < HLF;
  endfunction

  task automatic chk(input logic act, input bit exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at t=%0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic compare_all(input string req_ref);
    bit r0, r1;
    r0 = ref_lvl(cnt_m, int'(off0));
    r1 = ref_lvl(cnt_m, int'(off1));
    chk(drive, cnt_m < HLF, "R2", "drive_o");
    chk(strobe, cnt_m == 0, "R3", "strobe_o");
    chk(bitq, bit_m[0], "R5", "bit_o");
    chk(refw, bit_m[0] ? r1 : r0, req_ref, "ref_o");
  endtask

  task automatic run(input int cycles, input int mode, input string req_ref);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all(req_ref);
      if (mode == 1 && cnt_m == N-1) mbit = ~mbit;  // alternate once per period
      if (mode == 2) mbit = ~mbit;                    // toggle every clock
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(drive, 1'b1, "R1", "drive_o in reset");
    chk(strobe, 1'b1, "R1", "strobe_o in reset");
    chk(bitq, 1'b0, "R1", "bit_o in reset");
    off0 = 5'd8; off1 = 5'd24; mbit = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe, 1'b0, "R1", "count 1 after release");
    chk(drive, 1'b1, "R1", "drive_o count 1");
    // R4/R6 quarter-period pair, bit alternating per period
    run(8*N, 1, "R4 R6");
    // R5 bit toggles every clock: only strobe-cycle value latched
    run(8*N, 2, "R5 R6");
    // R7 degenerate offsets
    off0 = 5'd0; off1 = 5'd16; mbit = 1'b0;
    for (int i = 0; i < 4*N; i++) begin
      @(negedge clk);
      compare_all("R7");
      chk(refw, bitq ? ~drive : drive, "R7", "ref vs drive");
      if (cnt_m == N-1) mbit = ~mbit;
    end
    // R4 wrap-adjacent offsets
    off0 = 5'd31; off1 = 5'd1;
    run(6*N, 1, "R4 R6");
    // R1 mid-period asynchronous reset
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(drive, 1'b1, "R1", "drive_o async reset");
    chk(strobe, 1'b1, "R1", "strobe_o async reset");
    chk(bitq, 1'b0, "R1", "bit_o async reset");
    @(negedge clk);
    rst_n = 1'b1;
    run(3*N, 2, "R4 R6");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule